// File: doc/BRIEF.md
# Synchronous Burst Flash Read Engine

This block serves read requests from an internal host port by running clocked burst reads against a synchronous NOR flash or a cellular RAM device. The host hands over a start byte address and a beat count. The engine starts a burst on the memory side. It waits a programmable number of clocks before the first sample. It then returns 16-bit beats, in address order, through a valid-qualified data stream. The memory clock is the engine's own clock. The `mem_clk_en` output tells an external clock gate when the memory clock must run.

The device can stall the data phase through its wait pin. The engine can be told three things about that pin: whether to honour it, which level means "wait", and whether an asserted wait spoils the data of the same cycle or of the next one. Stalled cycles keep the clock running and the device selected. Their bus contents are thrown away. Some devices forbid bursts that cross a page. For these, a page size can be set, and the engine then cuts a host request into several device bursts without the host noticing.

Back-pressure rules: the request port is valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high, and `req_ready` is high only while the engine is idle. The read data stream has no ready input, because a running synchronous burst cannot be held. The sink must take each beat in the cycle where `rd_valid` is high.

Top module: `sbr_reader`

## Requirements
- R1: `req_ready` is high exactly when no request is in progress. A request is taken on an edge with `req_valid` and `req_ready` both high. `req_len` holds the beat count minus one. Bit 0 of `req_addr` is ignored, and the word address is `req_addr >> 1`.
- R2: Each device burst begins with one cycle in which `mem_adv_n` is low, `mem_cs_n` is low and `mem_oe_n` is high. In that cycle `mem_addr` carries the word address of the burst's first beat. `mem_adv_n` is high in the following cycle.
- R3: With the ADV cycle numbered 0, `mem_oe_n` is low from cycle 1 onward. The first data cycle is cycle `cfg_dlat`+2. Data present on `mem_dq` in a data cycle appears on `rd_data` with `rd_valid` high one cycle later.
- R4: With `cfg_wait_en` = 0, `mem_wait` has no effect, and every data cycle yields a beat.
- R5: `cfg_wait_pol` = 1 means wait is asserted when `mem_wait` is high. `cfg_wait_pol` = 0 means wait is asserted when `mem_wait` is low.
- R6: With `cfg_wait_cur` = 1, an asserted wait in a data cycle discards that cycle's data. Wait is not examined before the first data cycle.
- R7: With `cfg_wait_cur` = 0, an asserted wait in a data cycle discards the next cycle's data. The first data cycle of a burst is never discarded.
- R8: During discarded data cycles, `mem_clk_en` stays high and `mem_cs_n` and `mem_oe_n` stay low.
- R9: `cfg_page` selects the page: 1 = 128 bytes, 2 = 256, 3 = 512, 4 = 1024. Codes 0 and 5 to 7 disable splitting, so a whole request runs as one burst.
- R10: When a request reaches a page end before its last beat, the engine raises `mem_cs_n` for exactly one cycle. It then starts a new burst whose ADV cycle carries the first word address of the next page, with the full latency again.
- R11: The host receives exactly `req_len`+1 beats, whose data are the device words at consecutive word addresses from the start address.
- R12: `done` is high for one cycle, in the cycle after the last `rd_valid`. In that cycle `req_ready` is high again and `mem_cs_n` is high.
- R13: During and right after reset, `mem_cs_n`, `mem_adv_n` and `mem_oe_n` are high, while `mem_clk_en`, `rd_valid` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock, also the memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dlat | input | DLW (4) | Data latency setting |
| cfg_wait_en | input | 1 | Honour the wait pin |
| cfg_wait_pol | input | 1 | Asserted level of the wait pin |
| cfg_wait_cur | input | 1 | 1: wait spoils same cycle; 0: next cycle |
| cfg_page | input | 3 | Page size code for splitting |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request may be taken |
| req_addr | input | AW (24) | Start byte address |
| req_len | input | LW (10) | Beat count minus one |
| rd_valid | output | 1 | Read beat present |
| rd_data | output | 16 | Read beat data |
| done | output | 1 | One-cycle pulse after the last beat |
| mem_clk_en | output | 1 | Memory clock must run |
| mem_cs_n | output | 1 | Device select, active low |
| mem_adv_n | output | 1 | Address-valid pulse, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | AW-1 (23) | Device word address |
| mem_dq | input | 16 | Device read data |
| mem_wait | input | 1 | Device wait pin |

## Verification
A device model in the bench places each word only in the data cycles that the configured latency, wait level and wait meaning make valid. It fills every other cycle with junk, so a latency off by one, a wrong polarity or a mixed-up wait meaning shows up as wrong or missing beats. Wait patterns are run in both meanings and both polarities. The wait pin is also held asserted during the latency phase, which separates "examined after latency" from "examined always". With waits disabled, the pin toggles to show that it is ignored. Requests that start just below a page end are run with several page codes, plus disabled and reserved codes. The number of ADV pulses, their addresses and the select gap tell a correct split apart from no split or a split at the wrong place.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADV,
    ST_LAT,
    ST_DATA,
    ST_GAP,
    ST_FINISH
  } sbr_state_e;

  // Page length in 16-bit words for a page code; 0 means no splitting.
  function automatic int page_words(input logic [2:0] code);
    case (code)
      3'd1:    return 64;
      3'd2:    return 128;
      3'd3:    return 256;
      3'd4:    return 512;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sbr_chunk.sv
// Beats that the next device burst may carry: what is left of the request,
// clipped at the end of the current page.
module sbr_chunk #(
  parameter int WAW = 23,
  parameter int CW  = 11
) (
  input  logic [WAW-1:0] waddr,
  input  logic [CW-1:0]  left,
  input  logic [2:0]     page_code,
  output logic [CW-1:0]  beats
);
  import sbr_pkg::*;

  logic [CW-1:0] low_addr;
  logic [CW-1:0] pw;
  logic [CW-1:0] offset;
  logic [CW-1:0] to_end;

  generate
    if (WAW >= CW) begin : g_trunc
      assign low_addr = waddr[CW-1:0];
    end else begin : g_ext
      assign low_addr = {{(CW-WAW){1'b0}}, waddr};
    end
  endgenerate

  always_comb begin
    pw     = CW'(page_words(page_code));
    offset = low_addr & (pw - CW'(1));
    to_end = pw - offset;
    if (pw == '0) beats = left;
    else          beats = (left < to_end) ? left : to_end;
  end

endmodule

// File: rtl/sbr_wait_qual.sv
// Decides whether the current data cycle carries a usable beat.
module sbr_wait_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic in_data,
  input  logic wait_pin,
  input  logic en,
  input  logic pol,
  input  logic cur,
  output logic beat_ok
);
  logic wait_act;
  logic prev_act;

  assign wait_act = in_data && en && (wait_pin == pol);

  always_ff @(posedge clk) begin
    if (!rst_n) prev_act <= 1'b0;
    else        prev_act <= wait_act;
  end

  assign beat_ok = in_data && (cur ? !wait_act : !prev_act);

endmodule

// File: rtl/sbr_ctrl.sv
// Burst sequencer: address phase, latency count, data phase, page gaps.
module sbr_ctrl #(
  parameter int WAW = 23,
  parameter int LW  = 10,
  parameter int DLW = 4,
  parameter int CW  = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DLW-1:0] cfg_dlat,
  input  logic           req_valid,
  input  logic [WAW-1:0] req_waddr,
  input  logic [LW-1:0]  req_len,
  input  logic [CW-1:0]  chunk_beats,
  input  logic           beat_ok,
  output logic           req_ready,
  output logic           in_data,
  output logic           capture,
  output logic           finish,
  output logic [WAW-1:0] cur_waddr,
  output logic [CW-1:0]  total_left,
  output logic [WAW-1:0] burst_addr,
  output logic           cs_n,
  output logic           adv_n,
  output logic           oe_n
);
  import sbr_pkg::*;

  sbr_state_e     state;
  logic [DLW-1:0] lat_cnt;
  logic [CW-1:0]  burst_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      lat_cnt    <= '0;
      cur_waddr  <= '0;
      total_left <= '0;
      burst_left <= '0;
      burst_addr <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_waddr  <= req_waddr;
            burst_addr <= req_waddr;
            total_left <= CW'(req_len) + CW'(1);
            state      <= ST_ADV;
          end
        end
        ST_ADV: begin
          burst_left <= chunk_beats;
          lat_cnt    <= '0;
          state      <= ST_LAT;
        end
        ST_LAT: begin
          if (lat_cnt == cfg_dlat) state <= ST_DATA;
          else                     lat_cnt <= lat_cnt + DLW'(1);
        end
        ST_DATA: begin
          if (beat_ok) begin
            cur_waddr  <= cur_waddr + WAW'(1);
            total_left <= total_left - CW'(1);
            burst_left <= burst_left - CW'(1);
            if (burst_left == CW'(1)) begin
              burst_addr <= cur_waddr + WAW'(1);
              state      <= (total_left == CW'(1)) ? ST_FINISH : ST_GAP;
            end
          end
        end
        ST_GAP:    state <= ST_ADV;
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign in_data   = (state == ST_DATA);
  assign capture   = in_data && beat_ok;
  assign finish    = (state == ST_FINISH);
  assign adv_n     = (state != ST_ADV);
  assign oe_n      = !((state == ST_LAT) || (state == ST_DATA));
  assign cs_n      = !((state == ST_ADV) || (state == ST_LAT) || (state == ST_DATA));

endmodule

// File: rtl/sbr_reader.sv
module sbr_reader #(
  parameter int AW  = 24,
  parameter int LW  = 10,
  parameter int DLW = 4,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DLW-1:0] cfg_dlat,
  input  logic           cfg_wait_en,
  input  logic           cfg_wait_pol,
  input  logic           cfg_wait_cur,
  input  logic [2:0]     cfg_page,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [LW-1:0]  req_len,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic           done,
  output logic           mem_clk_en,
  output logic           mem_cs_n,
  output logic           mem_adv_n,
  output logic           mem_oe_n,
  output logic [AW-2:0]  mem_addr,
  input  logic [DW-1:0]  mem_dq,
  input  logic           mem_wait
);
  localparam int WAW = AW - 1;
  localparam int CW  = (LW + 1 > 11) ? LW + 1 : 11;

  logic           in_data;
  logic           beat_ok;
  logic           capture;
  logic           finish;
  logic [WAW-1:0] cur_waddr;
  logic [CW-1:0]  total_left;
  logic [CW-1:0]  chunk_beats;
  logic [WAW-1:0] burst_addr;

  sbr_chunk #(.WAW(WAW), .CW(CW)) u_chunk (
    .waddr     (cur_waddr),
    .left      (total_left),
    .page_code (cfg_page),
    .beats     (chunk_beats)
  );

  sbr_wait_qual u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .wait_pin (mem_wait),
    .en       (cfg_wait_en),
    .pol      (cfg_wait_pol),
    .cur      (cfg_wait_cur),
    .beat_ok  (beat_ok)
  );

  sbr_ctrl #(.WAW(WAW), .LW(LW), .DLW(DLW), .CW(CW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_dlat    (cfg_dlat),
    .req_valid   (req_valid),
    .req_waddr   (req_addr[AW-1:1]),
    .req_len     (req_len),
    .chunk_beats (chunk_beats),
    .beat_ok     (beat_ok),
    .req_ready   (req_ready),
    .in_data     (in_data),
    .capture     (capture),
    .finish      (finish),
    .cur_waddr   (cur_waddr),
    .total_left  (total_left),
    .burst_addr  (burst_addr),
    .cs_n        (mem_cs_n),
    .adv_n       (mem_adv_n),
    .oe_n        (mem_oe_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= mem_dq;
      done <= finish;
    end
  end

  assign mem_clk_en = !mem_cs_n;
  assign mem_addr   = burst_addr;

endmodule

// File: rtl/sbr_reader_chk.sv
module sbr_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rd_valid,
  input logic done,
  input logic mem_cs_n,
  input logic mem_adv_n,
  input logic mem_oe_n
);
  // R2
  adv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> mem_adv_n);
  // R2
  adv_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (!mem_cs_n && mem_oe_n));
  // R3
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> !mem_oe_n);
  // R10
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> $past(mem_cs_n));
  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n || rd_valid) |-> !req_ready);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_cs_n && req_ready && !rd_valid));
endmodule

bind sbr_reader sbr_reader_chk i_chk (.*);

// File: tb/test_sbr_reader.sv
`timescale 1ns/1ps
module test_sbr_reader;
  localparam int AW = 24;
  localparam int LW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  t_dlat = 4'd2;
  logic        t_wen = 1'b0, t_pol = 1'b1, t_cur = 1'b0;
  logic [2:0]  t_page = 3'd0;
  logic        req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic        req_ready, rd_valid, done;
  logic [15:0] rd_data;
  logic        mem_clk_en, mem_cs_n, mem_adv_n, mem_oe_n;
  logic [AW-2:0] mem_addr;
  logic [15:0] mem_dq = 16'h0;
  logic        mem_wait = 1'b0;

  logic [31:0] t_mask = 32'h0;
  logic        t_latwait = 1'b0;

  int total = 0, bad = 0;
  int nbeats = 0, nadv = 0, beat_bad = 0, wait_bad = 0;
  int cyc = 0, first_adv = 0, first_rv = 0, cs_hi_run = 0, last_gap = 0;
  logic [AW-2:0] adv_log [0:7];
  logic [AW-2:0] exp_ptr = '0;
  logic [AW-2:0] mptr = '0;
  int mcnt = 0;

  always #2 clk = ~clk;

  sbr_reader i_sbr_reader (
    .clk(clk), .rst_n(rst_n), .cfg_dlat(t_dlat), .cfg_wait_en(t_wen),
    .cfg_wait_pol(t_pol), .cfg_wait_cur(t_cur), .cfg_page(t_page),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .mem_clk_en(mem_clk_en), .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq(mem_dq),
    .mem_wait(mem_wait)
  );

  function automatic logic [15:0] pat(input logic [AW-2:0] w);
    return w[15:0] ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Device model and host-side monitor, both acting at the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (!mem_adv_n) begin
      mcnt = 0;
      mptr = mem_addr;
      if (nadv == 0) first_adv = cyc;
      if (nadv > 0) last_gap = cs_hi_run;
      if (nadv < 8) adv_log[nadv] = mem_addr;
      nadv++;
    end else if (!mem_cs_n) begin
      mcnt++;
    end
    if (mem_cs_n) cs_hi_run++;
    else          cs_hi_run = 0;

    if (!mem_cs_n && mcnt >= int'(t_dlat) + 2) begin
      int  k = mcnt - (int'(t_dlat) + 2);
      bit  w = t_mask[k % 32];
      bit  ok;
      if (!t_wen)     ok = 1'b1;
      else if (t_cur) ok = !w;
      else            ok = (k == 0) || !t_mask[(k - 1) % 32];
      mem_wait = t_pol ? w : !w;
      if (ok) begin
        mem_dq = pat(mptr);
        mptr   = mptr + 1'b1;
      end else begin
        mem_dq = 16'hDEAD;
        // R8: a discarded cycle keeps the clock on and the device selected
        if (mem_oe_n || !mem_clk_en) wait_bad++;
      end
    end else begin
      mem_dq   = 16'hBEEF;
      mem_wait = (t_latwait && !mem_cs_n) ? t_pol : !t_pol;
    end

    if (rd_valid) begin
      if (nbeats == 0) first_rv = cyc;
      if (rd_data != pat(exp_ptr)) begin
        beat_bad++;
        chk(1'b0, "R11", "beat data", rd_data, pat(exp_ptr));
      end
      exp_ptr = exp_ptr + 1'b1;
      nbeats++;
    end
  end

  task automatic run_req(input logic [AW-1:0] addr, input int beats,
                         input logic [3:0] dlat, input bit wen, input bit pol,
                         input bit cur, input logic [2:0] page,
                         input logic [31:0] mask, input bit latwait,
                         input string req);
    @(posedge clk);
    t_dlat = dlat; t_wen = wen; t_pol = pol; t_cur = cur; t_page = page;
    t_mask = mask; t_latwait = latwait;
    nbeats = 0; nadv = 0; beat_bad = 0; wait_bad = 0; last_gap = 0;
    exp_ptr = addr[AW-1:1];
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = addr; req_len = LW'(beats - 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready while busy", req_ready, 0);
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    chk(done == 1'b1, req, "done seen", done, 1);
    chk(nbeats == beats, "R11", "beat count", nbeats, beats);
    chk(beat_bad == 0, req, "bad beats", beat_bad, 0);
    chk(wait_bad == 0, "R8", "wait cycle framing", wait_bad, 0);
    chk(req_ready && mem_cs_n, "R12", "idle at done", {req_ready, mem_cs_n}, 3);
    @(negedge clk);
    chk(done == 1'b0, "R12", "done one cycle", done, 0);
  endtask

  task automatic t_reset;
    chk(mem_cs_n && mem_adv_n && mem_oe_n, "R13", "strobes high in reset",
        {mem_cs_n, mem_adv_n, mem_oe_n}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_clk_en && !rd_valid && !done && req_ready, "R13", "idle outputs",
        {mem_clk_en, rd_valid, done, req_ready}, 1);
    chk(mem_cs_n && mem_adv_n && mem_oe_n, "R13", "strobes high after reset",
        {mem_cs_n, mem_adv_n, mem_oe_n}, 7);
  endtask

  task automatic t_basic;
    run_req(24'h000100, 8, 4'd2, 0, 1, 0, 3'd0, 32'h0, 0, "R11");
    chk(nadv == 1, "R2", "single burst", nadv, 1);
    chk(adv_log[0] == 23'h80, "R2", "burst address", adv_log[0], 23'h80);
    chk(first_rv - first_adv == 5, "R3", "latency dlat=2", first_rv - first_adv, 5);
  endtask

  task automatic t_latency;
    run_req(24'h000200, 4, 4'd0, 0, 1, 0, 3'd0, 32'h0, 0, "R3");
    chk(first_rv - first_adv == 3, "R3", "latency dlat=0", first_rv - first_adv, 3);
    run_req(24'h000300, 5, 4'd7, 0, 1, 0, 3'd0, 32'h0, 0, "R3");
    chk(first_rv - first_adv == 10, "R3", "latency dlat=7", first_rv - first_adv, 10);
  endtask

  task automatic t_wait_off;
    // R4: the pin toggles but must be ignored
    run_req(24'h000400, 12, 4'd1, 0, 1, 1, 3'd0, 32'hA5A5_5A5A, 1, "R4");
    chk(first_rv - first_adv == 4, "R4", "no stall", first_rv - first_adv, 4);
  endtask

  task automatic t_wait_cur;
    // R6 R5: high-active, same-cycle meaning, pin asserted during latency
    run_req(24'h000500, 16, 4'd2, 1, 1, 1, 3'd0, 32'h0000_0C32, 1, "R6");
    chk(first_rv - first_adv == 5, "R6", "latency wait ignored", first_rv - first_adv, 5);
  endtask

  task automatic t_wait_next;
    // R7 R5: low-active, next-cycle meaning
    run_req(24'h000600, 16, 4'd3, 1, 0, 0, 3'd0, 32'h0000_1907, 1, "R7");
    chk(first_rv - first_adv == 6, "R7", "first beat kept", first_rv - first_adv, 6);
  endtask

  task automatic t_split;
    run_req(24'h000070, 16, 4'd1, 0, 1, 0, 3'd1, 32'h0, 0, "R10");
    chk(nadv == 2, "R9", "128-byte split count", nadv, 2);
    chk(adv_log[1] == 23'h40, "R10", "next page address", adv_log[1], 23'h40);
    chk(last_gap == 1, "R10", "select gap", last_gap, 1);
    run_req(24'h000070, 16, 4'd1, 0, 1, 0, 3'd0, 32'h0, 0, "R9");
    chk(nadv == 1, "R9", "split disabled", nadv, 1);
    run_req(24'h000070, 16, 4'd1, 0, 1, 0, 3'd7, 32'h0, 0, "R9");
    chk(nadv == 1, "R9", "reserved code", nadv, 1);
    // R1: odd start address, bit 0 dropped
    run_req(24'h0000F1, 10, 4'd0, 0, 1, 0, 3'd2, 32'h0, 0, "R1");
    chk(nadv == 2, "R9", "256-byte split count", nadv, 2);
    chk(adv_log[0] == 23'h78, "R1", "bit0 ignored", adv_log[0], 23'h78);
    chk(adv_log[1] == 23'h80, "R10", "256 next page", adv_log[1], 23'h80);
  endtask

  task automatic t_split_long;
    run_req(24'h0003F0, 600, 4'd2, 1, 1, 1, 3'd4, 32'h0001_0210, 0, "R10");
    chk(nadv == 3, "R10", "1024-byte split count", nadv, 3);
    chk(adv_log[1] == 23'h200, "R10", "second page", adv_log[1], 23'h200);
    chk(adv_log[2] == 23'h400, "R10", "third page", adv_log[2], 23'h400);
    run_req(24'h0001F8, 8, 4'd1, 0, 1, 0, 3'd3, 32'h0, 0, "R9");
    chk(nadv == 2, "R9", "512-byte split count", nadv, 2);
    chk(adv_log[1] == 23'h100, "R10", "512 next page", adv_log[1], 23'h100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_latency();
    t_wait_off();
    t_wait_cur();
    t_wait_next();
    t_split();
    t_split_long();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule